// File: doc/BRIEF.md
# DDR Region Security Filter

This block sits in front of a DRAM port and decides, for each transaction, whether it may proceed. It holds a set of programmable address windows with one-megabyte granularity. Each window can be marked secure and armed. A non-secure transaction that lands inside an armed secure window is refused. All memory outside the windows is open to everyone, and a global bypass bit turns all checking off.

Configuration uses a small 32-bit word port. Each window takes two consecutive register slots. The even slot holds the first megabyte plus the control bits. The odd slot holds the last megabyte, inclusive. The odd slot of the highest window also carries the global bypass bit.

Every write is masked. The upper half of the write data enables individual bits of the lower half, so firmware can change one field without reading the register first. The decision output is combinational from the transaction inputs and the current register state.

Top module: `ddr_region_guard`

## Requirements
- R1: After reset, every register reads zero except slot 15 (the highest window's end slot), which reads 0x00008000 because bypass is set; all transactions are permitted.
- R2: On a write, bit n of the selected register (n in 0..15) takes data bit n only when write-data bit n+16 is 1. A mask bit of 1 with a data bit of 0 clears that bit. Bits whose mask bit is 0 keep their value.
- R3: A read returns the stored 16 bits in rdata[15:0], and rdata[31:16] is always zero.
- R4: Register layout. Slot 2k belongs to window k: bits 11:0 hold the start megabyte, bit 15 marks the window secure, and bit 14 arms its check. Slot 2k+1 holds the end megabyte in bits 11:0. Bit 15 of slot 15 is the global bypass.
- R5: A transaction is denied (txn_permit=0) only when all three hold: bypass is clear, txn_ns=1, and the address lies in a window that is both secure and armed.
- R6: An address lies in window k when its megabyte index addr[31:20] is at least start and at most end, with both bounds inclusive.
- R7: A transaction with txn_ns=0 is always permitted.
- R8: While bypass is set, every transaction is permitted.
- R9: A window that is secure but not armed, or armed but not secure, denies nothing.
- R10: An address outside every armed secure window is permitted.
- R11: A register write takes effect on decisions from the clock cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register slot index |
| cfg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| cfg_rdata | output | 32 | Read data of slot cfg_idx, upper half zero |
| txn_addr | input | 32 | Transaction byte address |
| txn_ns | input | 1 | 1 = non-secure transaction |
| txn_permit | output | 1 | 1 = allow, 0 = deny |

## Verification
The bench builds the block with its defaults: eight windows, a 32-bit address and a 20-bit megabyte shift. These values put both ends of the megabyte range (index 0 and index 0xFFF) within reach, along with the bypass bit shared with the highest window's end field. The bench checks the exact first and last byte of a window, a single-megabyte window, each control bit alone, and a decision taken in the same cycle as a write that changes it.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;
  localparam int REG_DW      = 16;
  localparam int CTL_SEC_BIT = 15;
  localparam int CTL_ARM_BIT = 14;
  localparam int BYP_BIT     = 15;
endpackage

// File: rtl/rgn_regfile.sv
module rgn_regfile
  import rgn_guard_pkg::*;
#(
  parameter int NUM_REG = 16,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [2*REG_DW-1:0]             wdata,
  output logic [2*REG_DW-1:0]             rdata,
  output logic [NUM_REG-1:0][REG_DW-1:0]  regs
);
  logic [REG_DW-1:0] wmask, wval;
  assign wmask = wdata[2*REG_DW-1:REG_DW];
  assign wval  = wdata[REG_DW-1:0];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    localparam logic [REG_DW-1:0] RST_VAL =
      (i == NUM_REG-1) ? (REG_DW'(1) << BYP_BIT) : '0;
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RST_VAL;
      else if (we && idx == IDX_W'(i))
        regs[i] <= (regs[i] & ~wmask) | (wval & wmask);
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(i)) |=> $stable(regs[i]));
    // R2
    masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IDX_W'(i)) |=>
        (((regs[i] ^ $past(regs[i])) & ~$past(wmask)) == '0));
  end

  assign rdata = {{REG_DW{1'b0}}, regs[idx]};

  // R1
  rst_bypass_chk: assert property (@(posedge clk)
    rst |=> regs[NUM_REG-1][BYP_BIT]);
endmodule

// File: rtl/rgn_match.sv
module rgn_match #(
  parameter int FLD_W = 12
) (
  input  logic [FLD_W-1:0] mb_idx,
  input  logic [FLD_W-1:0] lo,
  input  logic [FLD_W-1:0] hi,
  input  logic             sec,
  input  logic             arm,
  output logic             hit
);
  assign hit = sec && arm && (mb_idx >= lo) && (mb_idx <= hi);
endmodule

// File: rtl/ddr_region_guard.sv
module ddr_region_guard
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN  = 8,
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 20,
  localparam int NUM_REG = 2 * NUM_RGN,
  localparam int IDX_W   = $clog2(NUM_REG),
  localparam int FLD_W   = ADDR_W - MB_SHIFT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [2*REG_DW-1:0] cfg_wdata,
  output logic [2*REG_DW-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic                txn_ns,
  output logic                txn_permit
);
  logic [NUM_REG-1:0][REG_DW-1:0] regs;
  logic [NUM_RGN-1:0]             hit;
  logic [FLD_W-1:0]               mb_idx;
  logic                           bypass;

  rgn_regfile #(.NUM_REG(NUM_REG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs(regs)
  );

  assign mb_idx = txn_addr[ADDR_W-1:MB_SHIFT];
  assign bypass = regs[NUM_REG-1][BYP_BIT];

  for (genvar k = 0; k < NUM_RGN; k++) begin : g_rgn
    rgn_match #(.FLD_W(FLD_W)) u_match (
      .mb_idx(mb_idx),
      .lo(regs[2*k][FLD_W-1:0]),
      .hi(regs[2*k+1][FLD_W-1:0]),
      .sec(regs[2*k][CTL_SEC_BIT]),
      .arm(regs[2*k][CTL_ARM_BIT]),
      .hit(hit[k])
    );
  end

  assign txn_permit = bypass || !txn_ns || !(|hit);

  // R7
  secure_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !txn_ns |-> txn_permit);
  // R5
  deny_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !txn_permit |-> (txn_ns && !regs[NUM_REG-1][BYP_BIT]));
  // R8
  bypass_open_chk: assert property (@(posedge clk) disable iff (rst)
    regs[NUM_REG-1][BYP_BIT] |-> txn_permit);
endmodule

// File: tb/ddr_region_guard_tb.sv
module ddr_region_guard_tb;
  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [31:0] txn_addr = 0;
  logic        txn_ns = 0;
  logic        txn_permit;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  ddr_region_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .txn_addr(txn_addr), .txn_ns(txn_ns), .txn_permit(txn_permit)
  );

  // monitor: samples between edges
  initial forever begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_rd ? cfg_rdata : {31'd0, txn_permit};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic chk_rd(input logic [3:0] idx, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_idx = idx;
    q.push_back('{1'b1, e, tag});
  endtask

  task automatic chk_tx(input logic [31:0] a, input logic ns, input logic e, input string tag);
    @(negedge clk);
    txn_addr = a; txn_ns = ns;
    q.push_back('{1'b0, {31'd0, e}, tag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int i = 0; i < 16; i++)
      chk_rd(4'(i), (i == 15) ? 32'h0000_8000 : 32'h0, "R1 reset read");
    chk_tx(32'h0000_0000, 1, 1, "R1 reset permit");
    // R3 upper half zero
    wr(0, 32'hFFFF_FFFF);
    chk_rd(0, 32'h0000_FFFF, "R3 upper zero");
    wr(0, 32'hFFFF_0000);
    chk_rd(0, 32'h0, "R2 clear all");
    // R2 masked writes
    wr(2, 32'h00FF_00AB);
    chk_rd(2, 32'h0000_00AB, "R2 low byte");
    wr(2, 32'h000F_FFF5);
    chk_rd(2, 32'h0000_00A5, "R2 nibble only");
    wr(2, 32'h0000_FFFF);
    chk_rd(2, 32'h0000_00A5, "R2 no mask no change");
    wr(2, 32'hFFFF_0000);
    // window 0: MB 0..31, secure+armed
    wr(0, 32'hCFFF_C000);
    wr(1, 32'h0FFF_001F);
    chk_tx(32'h0100_0000, 1, 1, "R8 bypass open");
    wr(15, 32'h8000_0000);
    chk_rd(15, 32'h0, "R4 bypass cleared");
    chk_tx(32'h0000_0000, 1, 0, "R5 first byte denied");
    chk_tx(32'h01FF_FFFF, 1, 0, "R6 last byte denied");
    chk_tx(32'h0200_0000, 1, 1, "R6 past end permitted");
    chk_tx(32'h0050_0000, 0, 1, "R7 secure permitted");
    // window 3: MB 100 only, armed not secure
    wr(6, 32'h4FFF_4064);
    wr(7, 32'h0FFF_0064);
    chk_rd(6, 32'h0000_4064, "R4 start slot");
    chk_tx(32'h0640_0000, 1, 1, "R9 armed only");
    wr(6, 32'hC000_8000);
    chk_tx(32'h064F_FFFF, 1, 1, "R9 secure only");
    wr(6, 32'h4000_4000);
    chk_tx(32'h064F_FFFF, 1, 0, "R6 single MB denied");
    chk_tx(32'h0650_0000, 1, 1, "R6 next MB permitted");
    chk_tx(32'h063F_FFFF, 1, 1, "R6 prev MB permitted");
    // R11 write timing: disarm window 3 while probing
    @(negedge clk);
    cfg_we = 1; cfg_idx = 6; cfg_wdata = 32'h4000_0000;
    txn_addr = 32'h0640_0000; txn_ns = 1;
    q.push_back('{1'b0, 32'd0, "R11 old state same cycle"});
    @(negedge clk);
    cfg_we = 0;
    q.push_back('{1'b0, 32'd1, "R11 new state next cycle"});
    // R10 outside
    chk_tx(32'hFFF0_0000, 1, 1, "R10 outside windows");
    // window 7 at top
    wr(14, 32'hCFFF_CFFF);
    wr(15, 32'h0FFF_0FFF);
    chk_rd(15, 32'h0000_0FFF, "R4 end slot keeps bypass");
    chk_tx(32'hFFFF_FFFF, 1, 0, "R5 top MB denied");
    wr(15, 32'h8000_8000);
    chk_rd(15, 32'h0000_8FFF, "R4 bypass bit 15");
    chk_tx(32'hFFFF_FFFF, 1, 1, "R8 bypass reenabled");
    chk_tx(32'h0000_0000, 1, 1, "R8 bypass window 0");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule